// File: doc/BRIEF.md
# State Access Permission Checker

This combinational block decides whether an access to optional per-extension state, or to one of the lower-level state-enable CSRs, is allowed in the current privilege mode. It also decides which exception a refused access raises. A register bank elsewhere supplies the effective enable vectors for three levels: machine, hypervisor and supervisor. The access is named by a kind code, a register index and a bit index. The block returns exactly one of three outcomes: allow, illegal-instruction or virtual-instruction.

Each level's enables gate only the modes below that level. A refusal by the machine level always yields illegal-instruction. A refusal by the hypervisor level, in a virtual mode, yields virtual-instruction. A refusal by the supervisor level yields illegal-instruction. When the F extension is absent, any floating-point instruction is treated as a touch of the float control/status register. That access is governed by bit 1 of enable register 0, and the select inputs are ignored.

Top module: `state_access_checker`

## Requirements
- R1: When mode_i[1:0] is 2'b11 (machine mode), the result is allow for every kind, enable pattern and value of mode_i[2].
- R2: kind_i = 0 (ungated) always gives allow.
- R3: For kinds 1, 2 and a gated 3, from any non-machine mode, a clear machine bit at flat index reg*64+bit gives illegal-instruction, also in VS/VU modes.
- R4: In a virtual mode (mode_i[2]=1, level not machine), a set machine bit together with a clear hypervisor bit at reg*64+bit gives virtual-instruction.
- R5: Hypervisor enables have no effect in non-virtual modes (mode_i[2]=0).
- R6: For kind 1 (user-level state) from U or VU (mode_i[1:0]=2'b00), once the machine and hypervisor checks pass, the supervisor bit at reg*32+bit must be set, or the result is illegal-instruction. A bit index of 32 or more counts as a clear supervisor bit.
- R7: Supervisor enables have no effect from S/VS modes, or for kind 2 (supervisor-only state). Level code 2'b10 acts as S.
- R8: For kind 3 (floating-point instruction), f_absent_i=0 gives allow. With f_absent_i=1 it behaves as kind 1 at register 0, bit 1, whatever sel_reg_i and sel_bit_i hold.
- R9: Access to the state-enable CSRs is checked as kind 2 at bit 63. From S it depends only on the machine bit 63. From VS, a clear hypervisor bit 63 gives virtual-instruction.
- R10: Exactly one of allow_o, illegal_o and virtual_o is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | [2] virtual, [1:0] level: 00 U, 01 S, 10 S, 11 M |
| kind_i | input | 2 | 0 ungated, 1 user-level state, 2 supervisor-only state, 3 FP instruction |
| sel_reg_i | input | 2 | enable register index |
| sel_bit_i | input | 6 | bit index within the register |
| f_absent_i | input | 1 | F extension disabled |
| m_en_i | input | 256 | machine enables, register r in bits r*64 up |
| h_en_i | input | 256 | hypervisor enables, same layout |
| s_en_i | input | 128 | supervisor enables, register r in bits r*32 up |
| allow_o | output | 1 | access permitted |
| illegal_o | output | 1 | raise illegal-instruction |
| virtual_o | output | 1 | raise virtual-instruction |

## Verification
The hardest case to reach is a VU-mode access that the hypervisor and the supervisor levels both refuse while the machine level permits it. The outcome must then be virtual-instruction and not illegal-instruction. Random stimulus rarely lines up three enable bits at one index this way. The bench therefore builds such vectors directly: it starts from all-ones enables and clears chosen bits. It also clears bits at neighbouring indices and at the floating-point remap location, so that a wrong index or a missed remap shows up as a wrong outcome.

// File: rtl/state_access_checker.sv
module state_access_checker #(
  parameter int NREG   = 4,
  parameter int MW     = 64,
  parameter int SW     = 32,
  parameter int FP_BIT = 1,
  localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int BW    = $clog2(MW)
) (
  input  logic [2:0]         mode_i,
  input  logic [1:0]         kind_i,
  input  logic [RW-1:0]      sel_reg_i,
  input  logic [BW-1:0]      sel_bit_i,
  input  logic               f_absent_i,
  input  logic [NREG*MW-1:0] m_en_i,
  input  logic [NREG*MW-1:0] h_en_i,
  input  logic [NREG*SW-1:0] s_en_i,
  output logic               allow_o,
  output logic               illegal_o,
  output logic               virtual_o
);
  localparam int SBW = $clog2(SW);
  localparam logic [1:0] K_USER = 2'd1, K_SUPER = 2'd2, K_FP = 2'd3;

  logic [MW-1:0] m_word [NREG];
  logic [MW-1:0] h_word [NREG];
  logic [SW-1:0] s_word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_split
    assign m_word[g] = m_en_i[g*MW +: MW];
    assign h_word[g] = h_en_i[g*MW +: MW];
    assign s_word[g] = s_en_i[g*SW +: SW];
  end

  logic is_m, is_u, virt;
  assign is_m = (mode_i[1:0] == 2'b11);
  assign is_u = (mode_i[1:0] == 2'b00);
  assign virt = mode_i[2] & ~is_m;

  logic fp_cls, fp_gated, gated, user_cls;
  assign fp_cls   = (kind_i == K_FP);
  assign fp_gated = fp_cls & f_absent_i;
  assign gated    = (kind_i == K_USER) | (kind_i == K_SUPER) | fp_gated;
  assign user_cls = (kind_i == K_USER) | fp_gated;

  logic [RW-1:0] idx_reg;
  logic [BW-1:0] idx_bit;
  assign idx_reg = fp_cls ? '0 : sel_reg_i;
  assign idx_bit = fp_cls ? BW'(FP_BIT) : sel_bit_i;

  logic reg_ok, s_in_range;
  assign reg_ok     = ({1'b0, idx_reg} < (RW+1)'(NREG));
  assign s_in_range = ({1'b0, idx_bit} < (BW+1)'(SW));

  logic [MW-1:0] m_sel, h_sel;
  logic [SW-1:0] s_sel;
  assign m_sel = reg_ok ? m_word[idx_reg] : '0;
  assign h_sel = reg_ok ? h_word[idx_reg] : '0;
  assign s_sel = reg_ok ? s_word[idx_reg] : '0;

  logic m_ok, h_ok, s_ok;
  assign m_ok = m_sel[idx_bit];
  assign h_ok = h_sel[idx_bit];
  assign s_ok = s_in_range & s_sel[idx_bit[SBW-1:0]];

  logic m_deny, h_deny, s_deny;
  assign m_deny = gated & ~is_m & ~m_ok;
  assign h_deny = gated & virt & ~h_ok;
  assign s_deny = user_cls & is_u & ~s_ok;

  assign illegal_o = m_deny | (~h_deny & s_deny);
  assign virtual_o = ~m_deny & h_deny;
  assign allow_o   = ~(m_deny | h_deny | s_deny);
endmodule

// File: rtl/state_access_checker_sva.sv
module state_access_checker_sva #(
  parameter int NREG   = 4,
  parameter int MW     = 64,
  parameter int SW     = 32,
  parameter int FP_BIT = 1,
  localparam int RW    = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int BW    = $clog2(MW)
) (
  input logic [2:0]         mode_i,
  input logic [1:0]         kind_i,
  input logic [RW-1:0]      sel_reg_i,
  input logic [BW-1:0]      sel_bit_i,
  input logic               f_absent_i,
  input logic [NREG*MW-1:0] m_en_i,
  input logic [NREG*MW-1:0] h_en_i,
  input logic [NREG*SW-1:0] s_en_i,
  input logic               allow_o,
  input logic               illegal_o,
  input logic               virtual_o
);
  logic known;
  assign known = !$isunknown({mode_i, kind_i, sel_reg_i, sel_bit_i, f_absent_i,
                              m_en_i, h_en_i, s_en_i});

  always_comb begin
    if (known) begin
      a_r10_one_outcome: assert ($countones({allow_o, illegal_o, virtual_o}) == 1);
      a_r1_machine_allows: assert (mode_i[1:0] != 2'b11 || allow_o);
      a_r2_ungated_allows: assert (kind_i != 2'd0 || allow_o);
      a_r4_virtual_needs_guest: assert (!virtual_o || (mode_i[2] && mode_i[1:0] != 2'b11));
      a_r8_fp_present_allows: assert (!(kind_i == 2'd3 && !f_absent_i) || allow_o);
      a_r6_upper_user_bit_denied: assert (!(kind_i == 2'd1 && mode_i[1:0] == 2'b00
                                            && int'(sel_bit_i) >= SW) || !allow_o);
      a_r5_no_virtual_outside_guest: assert (mode_i[2] || !virtual_o);
    end
  end
endmodule

bind state_access_checker state_access_checker_sva #(
  .NREG(NREG), .MW(MW), .SW(SW), .FP_BIT(FP_BIT)
) u_sva (.*);

// File: tb/state_access_checker_tb.sv
module state_access_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4, MW = 64, SW = 32;
  localparam int MBITS = NREG*MW, SBITS = NREG*SW;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] mode_i = '0;
  logic [1:0] kind_i = '0;
  logic [1:0] sel_reg_i = '0;
  logic [5:0] sel_bit_i = '0;
  logic f_absent_i = 1'b0;
  logic [MBITS-1:0] m_en_i = '0, h_en_i = '0;
  logic [SBITS-1:0] s_en_i = '0;
  logic allow_o, illegal_o, virtual_o;

  state_access_checker u_dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  localparam logic [MBITS-1:0] M1 = '1;
  localparam logic [SBITS-1:0] S1 = '1;

  // 0 allow, 1 illegal, 2 virtual
  function automatic logic [1:0] model(logic [2:0] md, logic [1:0] k, int r, int b,
                                       logic fa, logic [MBITS-1:0] m, logic [MBITS-1:0] h,
                                       logic [SBITS-1:0] s);
    if (md[1:0] == 2'b11) return 2'd0;
    if (k == 2'd0) return 2'd0;
    if (k == 2'd3) begin
      if (!fa) return 2'd0;
      r = 0; b = 1;
    end
    if (!m[r*MW+b]) return 2'd1;
    if (md[2] && !h[r*MW+b]) return 2'd2;
    if ((k == 2'd1 || k == 2'd3) && md[1:0] == 2'b00 && (b >= SW || !s[r*SW+b])) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [MBITS-1:0] mclr(logic [MBITS-1:0] v, int i);
    v[i] = 1'b0; return v;
  endfunction
  function automatic logic [SBITS-1:0] sclr(logic [SBITS-1:0] v, int i);
    v[i] = 1'b0; return v;
  endfunction

  task automatic drive(logic [2:0] md, logic [1:0] k, int r, int b, logic fa,
                       logic [MBITS-1:0] m, logic [MBITS-1:0] h, logic [SBITS-1:0] s,
                       string tag);
    @(posedge clk);
    #1;
    mode_i = md; kind_i = k; sel_reg_i = 2'(r); sel_bit_i = 6'(b);
    f_absent_i = fa; m_en_i = m; h_en_i = h; s_en_i = s;
    exp_q.push_back(model(md, k, r, b, fa, m, h, s));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [1:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        case ({allow_o, illegal_o, virtual_o})
          3'b100: a = 2'd0;
          3'b010: a = 2'd1;
          3'b001: a = 2'd2;
          default: a = 2'd3;
        endcase
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s: outcome actual=%0d expected=%0d (flags %b)", t, a, e,
                   {allow_o, illegal_o, virtual_o});
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD*100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int seed = 7;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs: U mode, ungated
    drive(3'b000, 2'd0, 0, 0, 0, '0, '0, '0, "R2 reset");
    // R1
    drive(3'b011, 2'd1, 1, 3, 1, '0, '0, '0, "R1 machine");
    drive(3'b111, 2'd2, 3, 63, 0, '0, '0, '0, "R1 machine virt bit");
    // R2
    drive(3'b100, 2'd0, 2, 7, 1, '0, '0, '0, "R2 ungated VU");
    // R3
    drive(3'b101, 2'd2, 2, 57, 0, mclr(M1, 2*64+57), '0, S1, "R3 VS machine deny");
    drive(3'b100, 2'd1, 0, 0, 0, mclr(M1, 0), '0, '0, "R3 VU machine first");
    drive(3'b001, 2'd2, 1, 62, 0, mclr(M1, 1*64+62), M1, S1, "R3 S machine deny");
    // R4
    drive(3'b101, 2'd2, 2, 57, 0, M1, mclr(M1, 2*64+57), S1, "R4 VS hyp deny");
    drive(3'b101, 2'd2, 2, 57, 0, M1, mclr(M1, 2*64+56), S1, "R4 neighbour bit allow");
    drive(3'b100, 2'd1, 1, 4, 0, M1, mclr(M1, 1*64+4), sclr(S1, 1*32+4), "R4 VU both deny virtual");
    // R5
    drive(3'b001, 2'd2, 0, 62, 0, M1, '0, '0, "R5 S ignores hyp");
    drive(3'b000, 2'd1, 3, 2, 0, M1, '0, S1, "R5 U ignores hyp");
    // R6
    drive(3'b000, 2'd1, 1, 5, 0, M1, M1, sclr(S1, 1*32+5), "R6 U sup deny");
    drive(3'b000, 2'd1, 1, 5, 0, M1, M1, sclr(S1, 1*32+6), "R6 U sup allow");
    drive(3'b000, 2'd1, 2, 40, 0, M1, M1, S1, "R6 upper bit deny");
    drive(3'b100, 2'd1, 3, 31, 0, M1, M1, sclr(S1, 3*32+31), "R6 VU sup deny illegal");
    // R7
    drive(3'b001, 2'd1, 0, 3, 0, M1, M1, '0, "R7 S ignores sup");
    drive(3'b000, 2'd2, 0, 3, 0, M1, M1, '0, "R7 super kind ignores sup");
    drive(3'b010, 2'd1, 2, 9, 0, M1, M1, '0, "R7 level 10 acts as S");
    drive(3'b101, 2'd1, 2, 9, 0, M1, M1, '0, "R7 VS ignores sup");
    // R8
    drive(3'b000, 2'd3, 2, 20, 0, '0, '0, '0, "R8 F present");
    drive(3'b000, 2'd3, 3, 9, 1, M1, M1, sclr(S1, 1), "R8 remap sup deny");
    drive(3'b000, 2'd3, 3, 9, 1, mclr(M1, 3*64+9), M1, SBITS'(2), "R8 remap allow");
    drive(3'b100, 2'd3, 2, 0, 1, mclr(M1, 1), M1, S1, "R8 VU machine deny");
    drive(3'b101, 2'd3, 1, 1, 1, M1, mclr(M1, 1), S1, "R8 VS hyp deny");
    // R9
    drive(3'b001, 2'd2, 0, 63, 0, mclr(M1, 63), '0, '0, "R9 S stateen deny");
    drive(3'b001, 2'd2, 0, 63, 0, M1, '0, '0, "R9 S stateen allow");
    drive(3'b101, 2'd2, 3, 63, 0, M1, mclr(M1, 3*64+63), S1, "R9 VS stateen virtual");
    // random patterns, outcome exclusivity checked each time
    for (int i = 0; i < 300; i++) begin
      logic [MBITS-1:0] m, h;
      logic [SBITS-1:0] s;
      int r, b;
      r = $urandom(seed) % NREG; seed = seed + 1;
      b = $urandom % MW;
      m = M1; h = M1; s = S1;
      if ($urandom % 3 == 0) m = mclr(m, r*MW+b);
      if ($urandom % 3 == 0) h = mclr(h, r*MW+b);
      if ($urandom % 3 == 0 && b < SW) s = sclr(s, r*SW+b);
      if ($urandom % 4 == 0) m = mclr(m, 1);
      if ($urandom % 4 == 0) h = mclr(h, 1);
      if ($urandom % 4 == 0) s = sclr(s, 1);
      drive(3'($urandom), 2'($urandom), r, b, 1'($urandom), m, h, s, "R10 random");
    end
    while (exp_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule